// File: doc/BRIEF.md
# Event Timer Channel Configuration and Interrupt Router

This block holds the 64-bit configuration and capability word for one comparator channel of a high-resolution event timer. It also turns that channel's timeout strobe into an interrupt request on a 32-line vector. The upper half of the word is a mask of the interrupt lines the channel may use. The bits of that mask that are permitted to change can be written only once after reset. The lower half holds the route number, the interrupt enable and the trigger type. All remaining bits are fixed at zero.

The counter and the comparator are outside the block and report a match through `timeout_i`. The status bit is also kept outside, and its clearing is reported through `sts_clr_i`. A route write that names a line the mask does not allow is corrected to the highest allowed line. The request is driven as a one-cycle pulse in edge mode, or held until the status is cleared in level mode. A legacy-replacement input silences the routed output.

Top module: `evt_chan_cfg`

## Requirements
- R1: After reset, `rdata_o` reads 64'h000F_DEFA_0000_0000, so the mask is 0x000FDEFA in bits 63:32, the route is 0, enable is 0 and type is 0. `irq_o` reads 0.
- R2: Bits 31:14, 8:3 and 0 of `rdata_o` always read 0. So do the mask bits 63:52, 45, 40, 34 and 32. Writing ones to any of these bits changes nothing.
- R3: The first write after reset stores `wdata_i[63:32]` ANDed with the writable set 0x000FDEFA into the mask. Every later write leaves the mask unchanged until the next reset.
- R4: A write whose route field `wdata_i[13:9]` names a line whose mask bit is set stores that route unchanged.
- R5: A write whose route names a line with a clear mask bit stores the highest-numbered set mask bit instead. The mask checked is the one in force after that same write. If the mask is empty, the stored route is 0, and because line 0 is never allowed, no line is ever driven.
- R6: Bit 2 is the interrupt enable and bit 1 is the trigger type (0 = edge, 1 = level). Both are read/write.
- R7: In edge mode with enable set, a clock edge that samples `timeout_i` high drives `irq_o` bit `route` high for exactly the following cycle. Every other bit of `irq_o` stays 0.
- R8: In level mode with enable set, a timeout drives `irq_o` bit `route` from the following cycle onward. The line stays high until an edge that samples `sts_clr_i` high with no timeout in the same cycle. A timeout that arrives while the line is held, including one in the same cycle as the clear, leaves the line high.
- R9: With enable clear, a timeout drives no interrupt line.
- R10: While `legacy_en_i` is high, `irq_o` is 0 in the following cycle. A level request that is already pending shows again once the input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the full 64-bit word |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Current register contents |
| timeout_i | input | 1 | Comparator match strobe |
| sts_clr_i | input | 1 | Channel status cleared strobe |
| legacy_en_i | input | 1 | Legacy replacement active; routed output is silenced |
| irq_o | output | 32 | Interrupt request vector, one bit per line |

## Verification
The level request has two drivers that can land in the same cycle: a new timeout that sets it and a status clear that drops it. The bench arms level mode on line 19. It then raises `timeout_i` and `sts_clr_i` together on one edge, and expects the line still high on the next cycle. A later clear applied alone must drop it. The same kind of collision is also exercised with the legacy input held high during a pending level request: the line must vanish for those cycles and reappear after the input drops.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  localparam int unsigned LINES_DEF = 32;
  localparam logic [31:0] CAP_WR_DEF  = 32'h000F_DEFA;
  localparam logic [31:0] CAP_RST_DEF = 32'h000F_DEFA;
  localparam int unsigned RT_LSB   = 9;
  localparam int unsigned IEN_BIT  = 2;
  localparam int unsigned TYPE_BIT = 1;
endpackage

// File: rtl/evt_cap_mask.sv
module evt_cap_mask #(
  parameter int unsigned LINES   = 32,
  parameter logic [LINES-1:0] WR_MASK = '0,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] mask_next_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_bit
    if (WR_MASK[i]) begin : g_once
      logic bit_q, done_q, bit_d;
      assign bit_d = (wr_i && !done_q) ? wdata_i[i] : bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bit_q  <= RST_VAL[i];
          done_q <= 1'b0;
        end else begin
          bit_q <= bit_d;
          if (wr_i) done_q <= 1'b1;
        end
      end
      assign mask_o[i]      = bit_q;
      assign mask_next_o[i] = bit_d;
    end else begin : g_fixed
      logic unused_bit;
      assign unused_bit     = wdata_i[i];
      assign mask_o[i]      = 1'b0;
      assign mask_next_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_route_fix.sv
module evt_route_fix #(
  parameter int unsigned LINES = 32,
  localparam int unsigned RT_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] mask_i,
  input  logic [RT_W-1:0]  req_i,
  output logic [RT_W-1:0]  route_o
);
  logic [RT_W-1:0] top_line;
  always_comb begin
    top_line = '0;
    for (int i = 0; i < LINES; i++) begin
      if (mask_i[i]) top_line = RT_W'(i);
    end
  end
  // keep legal request, else fall back to highest allowed line (0 when none)
  assign route_o = mask_i[req_i] ? req_i : top_line;
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int unsigned LINES = 32,
  localparam int unsigned RT_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             timeout_i,
  input  logic             clr_i,
  input  logic             legacy_i,
  input  logic             ien_i,
  input  logic             level_i,
  input  logic [RT_W-1:0]  route_i,
  input  logic [LINES-1:0] mask_i,
  output logic [LINES-1:0] irq_o
);
  logic             lvl_q, lvl_d, edge_fire, fire_any;
  logic [LINES-1:0] irq_q, irq_d;

  // new timeout wins over a clear in the same cycle
  assign lvl_d     = (timeout_i & ien_i & level_i) | (lvl_q & ~clr_i);
  assign edge_fire = timeout_i & ien_i & ~level_i;
  assign fire_any  = (edge_fire | lvl_d) & mask_i[route_i] & ~legacy_i;
  assign irq_d     = fire_any ? (LINES'(1) << route_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      irq_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
  import evt_chan_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter logic [LINES-1:0] CAP_WR  = CAP_WR_DEF,
  parameter logic [LINES-1:0] CAP_RST = CAP_RST_DEF,
  localparam int unsigned DW   = 2 * LINES,
  localparam int unsigned RT_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             timeout_i,
  input  logic             sts_clr_i,
  input  logic             legacy_en_i,
  output logic [LINES-1:0] irq_o
);
  logic [LINES-1:0] mask_q, mask_next;
  logic [RT_W-1:0]  route_q, route_fixed;
  logic             ien_q, type_q;

  evt_cap_mask #(.LINES(LINES), .WR_MASK(CAP_WR), .RST_VAL(CAP_RST)) u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en_i),
    .wdata_i     (wdata_i[DW-1:LINES]),
    .mask_o      (mask_q),
    .mask_next_o (mask_next)
  );

  evt_route_fix #(.LINES(LINES)) u_fix (
    .mask_i  (mask_next),
    .req_i   (wdata_i[RT_LSB +: RT_W]),
    .route_o (route_fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      ien_q   <= 1'b0;
      type_q  <= 1'b0;
    end else if (wr_en_i) begin
      route_q <= route_fixed;
      ien_q   <= wdata_i[IEN_BIT];
      type_q  <= wdata_i[TYPE_BIT];
    end
  end

  logic unused_wd;
  assign unused_wd = ^{wdata_i[LINES-1:RT_LSB+RT_W], wdata_i[RT_LSB-1:IEN_BIT+1], wdata_i[0]};

  always_comb begin
    rdata_o                    = '0;
    rdata_o[DW-1:LINES]        = mask_q;
    rdata_o[RT_LSB +: RT_W]    = route_q;
    rdata_o[IEN_BIT]           = ien_q;
    rdata_o[TYPE_BIT]          = type_q;
  end

  evt_irq_gen #(.LINES(LINES)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .timeout_i (timeout_i),
    .clr_i     (sts_clr_i),
    .legacy_i  (legacy_en_i),
    .ien_i     (ien_q),
    .level_i   (type_q),
    .route_i   (route_q),
    .mask_i    (mask_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/evt_chan_cfg_chk.sv
module evt_chan_cfg_chk #(
  parameter int unsigned LINES = 32,
  parameter logic [LINES-1:0] CAP_WR = '0,
  localparam int unsigned DW   = 2 * LINES,
  localparam int unsigned RT_W = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             timeout_i,
  input logic             sts_clr_i,
  input logic             legacy_en_i,
  input logic [DW-1:0]    rdata_o,
  input logic [LINES-1:0] irq_o
);
  logic             wr_seen_q;
  logic [LINES-1:0] rd_mask;
  logic [RT_W-1:0]  rd_route;

  assign rd_mask  = rdata_o[DW-1:LINES];
  assign rd_route = rdata_o[9 +: RT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_seen_q <= 1'b0;
    else if (wr_en_i) wr_seen_q <= 1'b1;
  end

  assert_fixed_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[LINES-1:9+RT_W] == '0) && (rdata_o[8:3] == '0) && !rdata_o[0]
    && ((rd_mask & ~CAP_WR) == '0));

  assert_mask_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_seen_q && wr_en_i |=> $stable(rd_mask));

  assert_route_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_route != '0) |-> rd_mask[rd_route]);

  assert_irq_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  assert_clear_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_clr_i && !timeout_i |=> irq_o == '0);

  assert_legacy_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_en_i |=> irq_o == '0);
endmodule

bind evt_chan_cfg evt_chan_cfg_chk #(.LINES(LINES), .CAP_WR(CAP_WR)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .timeout_i   (timeout_i),
  .sts_clr_i   (sts_clr_i),
  .legacy_en_i (legacy_en_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o)
);

// File: tb/evt_chan_cfg_tb.sv
`timescale 1ns/1ps
module evt_chan_cfg_tb_top;
  localparam logic [31:0] M0 = 32'h000F_DEFA;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        timeout_i = 1'b0;
  logic        sts_clr_i = 1'b0;
  logic        legacy_en_i = 1'b0;
  logic [31:0] irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] q_rd[$];
  logic [31:0] q_irq[$];
  string       q_tag[$];

  always #2.5 clk_i = ~clk_i;

  evt_chan_cfg dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i, .rdata_o,
    .timeout_i, .sts_clr_i, .legacy_en_i, .irq_o
  );

  function automatic logic [63:0] rdv(logic [31:0] m, logic [4:0] r, logic ien, logic typ);
    logic [63:0] v = '0;
    v[63:32] = m; v[13:9] = r; v[2] = ien; v[1] = typ;
    return v;
  endfunction

  function automatic logic [63:0] wv(logic [31:0] m, logic [4:0] r, logic ien, logic typ, logic junk);
    logic [63:0] v;
    v = {m, (junk ? 32'hFFFF_FFFF : 32'h0)};
    v[13:9] = r; v[2] = ien; v[1] = typ;
    return v;
  endfunction

  function automatic logic [31:0] ln(int i);
    return 32'd1 << i;
  endfunction

  // driver: apply one cycle of stimulus, queue the outputs expected after that edge
  task automatic step(logic wr, logic [63:0] wd, logic to, logic clr, logic leg,
                      logic [63:0] erd, logic [31:0] eirq, string tag);
    wr_en_i = wr; wdata_i = wd; timeout_i = to; sts_clr_i = clr; legacy_en_i = leg;
    @(posedge clk_i); #1;
    q_rd.push_back(erd); q_irq.push_back(eirq); q_tag.push_back(tag);
    wr_en_i = 1'b0; timeout_i = 1'b0; sts_clr_i = 1'b0;
  endtask

  task automatic do_reset();
    wr_en_i = 1'b0; timeout_i = 1'b0; sts_clr_i = 1'b0; legacy_en_i = 1'b0; wdata_i = '0;
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  // monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (q_rd.size() > 0) begin
        logic [63:0] erd;
        logic [31:0] eirq;
        string       tg;
        erd = q_rd.pop_front(); eirq = q_irq.pop_front(); tg = q_tag.pop_front();
        n_chk++;
        if (rdata_o !== erd || irq_o !== eirq) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq=%h expected rdata=%h irq=%h",
                   tg, rdata_o, irq_o, erd, eirq);
        end
      end
    end
  end

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, '0, 0, 0, 0, rdv(M0, 0, 0, 0), 0, "R1 reset state");
    step(0, '0, 1, 0, 0, rdv(M0, 0, 0, 0), 0, "R9 timeout while disabled");
    step(1, wv(32'hFFFF_FFFF, 5, 1, 0, 1), 0, 0, 0, rdv(M0, 5, 1, 0), 0, "R2 R3 first write, junk in fixed bits");
    step(1, wv(32'h0, 9, 1, 0, 0), 0, 0, 0, rdv(M0, 9, 1, 0), 0, "R3 R4 mask locked, legal route kept");
    step(0, '0, 1, 0, 0, rdv(M0, 9, 1, 0), ln(9), "R7 edge pulse");
    step(0, '0, 0, 0, 0, rdv(M0, 9, 1, 0), 0, "R7 pulse one cycle");
    step(0, '0, 1, 0, 0, rdv(M0, 9, 1, 0), ln(9), "R7 second timeout new pulse");
    step(1, wv(32'h0, 13, 1, 0, 0), 0, 0, 0, rdv(M0, 19, 1, 0), 0, "R5 line 13 not allowed");
    step(1, wv(32'h0, 2, 1, 0, 0), 0, 0, 0, rdv(M0, 19, 1, 0), 0, "R5 line 2 not allowed");
    step(1, wv(32'h0, 0, 1, 0, 0), 0, 0, 0, rdv(M0, 19, 1, 0), 0, "R5 line 0 not allowed");
    step(1, wv(32'h0, 12, 1, 0, 0), 0, 0, 0, rdv(M0, 12, 1, 0), 0, "R4 line 12 allowed");
    step(0, '0, 1, 0, 1, rdv(M0, 12, 1, 0), 0, "R10 edge under legacy");
    step(0, '0, 1, 0, 0, rdv(M0, 12, 1, 0), ln(12), "R7 edge after legacy drop");
    step(1, wv(32'h0, 19, 1, 1, 0), 0, 0, 0, rdv(M0, 19, 1, 1), 0, "R6 level mode set");
    step(0, '0, 1, 0, 0, rdv(M0, 19, 1, 1), ln(19), "R8 level asserted");
    step(0, '0, 0, 0, 0, rdv(M0, 19, 1, 1), ln(19), "R8 level held");
    step(0, '0, 1, 0, 0, rdv(M0, 19, 1, 1), ln(19), "R8 timeout while held");
    step(0, '0, 1, 1, 0, rdv(M0, 19, 1, 1), ln(19), "R8 timeout and clear together");
    step(0, '0, 0, 1, 0, rdv(M0, 19, 1, 1), 0, "R8 clear drops line");
    step(0, '0, 0, 0, 0, rdv(M0, 19, 1, 1), 0, "R8 stays low");
    step(0, '0, 1, 0, 1, rdv(M0, 19, 1, 1), 0, "R10 level under legacy");
    step(0, '0, 0, 0, 1, rdv(M0, 19, 1, 1), 0, "R10 still silenced");
    step(0, '0, 0, 0, 0, rdv(M0, 19, 1, 1), ln(19), "R10 pending level reappears");
    step(0, '0, 0, 1, 0, rdv(M0, 19, 1, 1), 0, "R8 clear after legacy");
    step(1, wv(32'h0, 19, 0, 1, 0), 0, 0, 0, rdv(M0, 19, 0, 1), 0, "R6 enable cleared");
    step(0, '0, 1, 0, 0, rdv(M0, 19, 0, 1), 0, "R9 level timeout disabled");
    step(0, '0, 0, 0, 0, rdv(M0, 19, 0, 1), 0, "R9 nothing held");
    step(1, wv(32'h0, 19, 0, 0, 0), 0, 0, 0, rdv(M0, 19, 0, 0), 0, "R6 edge, disabled");
    step(0, '0, 1, 0, 0, rdv(M0, 19, 0, 0), 0, "R9 edge timeout disabled");

    do_reset();
    step(0, '0, 0, 0, 0, rdv(M0, 0, 0, 0), 0, "R1 reset restores defaults");
    step(1, wv(32'h0, 7, 1, 0, 0), 0, 0, 0, rdv(32'h0, 0, 1, 0), 0, "R5 empty mask gives route 0");
    step(0, '0, 1, 0, 0, rdv(32'h0, 0, 1, 0), 0, "R5 no line with empty mask");
    step(1, wv(32'hFFFF_FFFF, 7, 1, 0, 0), 0, 0, 0, rdv(32'h0, 0, 1, 0), 0, "R3 mask stays empty after lock");
    step(0, '0, 0, 0, 0, rdv(32'h0, 0, 1, 0), 0, "R2 idle read");

    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule